// File: doc/BRIEF.md
# Intermittent Stuck-At Fault Injector

This block sits in the read path of one stored word, for example an entry of a register file or a reorder buffer. It imitates an intermittent stuck-at fault on a single bit of that word. The fault arrives in repeated bursts. Each burst is an active window, during which the chosen bit reads as a constant level, followed by an inactive window, during which the true stored value is seen again. Every bit other than the chosen one always passes through unchanged.

Burst lengths are random within a bounded range and are split evenly between the active and inactive windows. The first burst starts after a random delay once injection is enabled. All randomness comes from a 16-bit linear feedback shift register that is loaded from a seed at reset, so a given seed always gives the same fault pattern. A burst limit can stop injection after a set number of bursts. A saturating counter reports how many clock cycles carried an injected fault.

Top module: `isaf_injector`

## Requirements
- R1: While `fault_on` is low, `word_out` equals `word_in` on every bit. This covers the time before enable, the inactive windows, and the time after the last burst.
- R2: While `fault_on` is high, bit `bit_sel` of `word_out` reads as `stuck_hi`: a value of 1 forces the bit to 1 and a value of 0 forces it to 0. All other bits equal `word_in`.
- R3: `bit_sel` and `stuck_hi` are captured on the first clock edge at which `inject_en` is seen high while the block is idle. Changes to either input after that edge are ignored until `inject_en` has gone low and high again.
- R4: Each burst is L cycles long, with L in the range 10 to 30. The active window lasts floor(L/2) cycles, from 5 to 15. The inactive window that follows lasts the rest: the same length as the active window, or one cycle longer.
- R5: The first active cycle follows a random delay. `fault_on` first goes high between 2 and 17 clock edges after the edge that first samples `inject_en` high, counting that edge as 1.
- R6: When `burst_limit` is N > 0, exactly N active windows occur and the output then stays pass-through for as long as `inject_en` stays high. When `burst_limit` is 0, bursts repeat without end.
- R7: Pulling `inject_en` low ends any burst. `fault_on` is low after the next clock edge, and `inj_cycles` does not change after that edge.
- R8: `inj_cycles` is 0 after reset. It rises by one for each clock cycle in which `fault_on` was high, and it saturates at its maximum value.
- R9: The random generator is loaded from `seed` at reset. A seed of zero is replaced with 16'hACE1, so seed 0 and seed 16'hACE1 give the same fault pattern. Repeated runs with the same seed give the same pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inject_en | input | 1 | Allows bursts to be generated |
| seed | input | 16 | Value loaded into the random generator at reset |
| bit_sel | input | 3 | Index of the faulty bit within the word |
| stuck_hi | input | 1 | Stuck level: 1 for stuck-at-1, 0 for stuck-at-0 |
| burst_limit | input | 8 | Number of bursts to generate; 0 means no limit |
| word_in | input | 8 | Stored value being read |
| word_out | output | 8 | Read value, with the fault applied when active |
| fault_on | output | 1 | High during active windows |
| inj_cycles | output | 32 | Saturating count of cycles with the fault applied |

## Verification
The main function is tried with several seeds, with both stuck levels, with target bits at both ends of the word and in the middle, and with burst limits of 1, 3 and 5 and with no limit. Measuring the active and inactive run lengths checks that they fall inside the allowed ranges. The stuck-at-1 and stuck-at-0 runs show whether the forced level follows the selected polarity. Because `word_in` changes every cycle, a bit that merely passes through cannot be mistaken for a forced bit. The finite limits separate "stop after N bursts" from "repeat forever", and a zero seed compared against 16'hACE1 confirms that the seed is replaced.

// File: rtl/isaf_pkg.sv
package isaf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACT,
    ST_GAP,
    ST_DONE
  } isaf_state_e;

  // Burst length in [lo, hi] taken from a random word.
  function automatic logic [7:0] isaf_len(input logic [15:0] r,
                                          input int unsigned lo,
                                          input int unsigned hi);
    int unsigned span;
    span = hi - lo + 1;
    return 8'(lo + (32'(r) % span));
  endfunction

  // Active part of a burst: floor of half.
  function automatic logic [7:0] isaf_act(input logic [7:0] len);
    return len >> 1;
  endfunction

  // Inactive part: whatever remains (ceiling of half).
  function automatic logic [7:0] isaf_gap(input logic [7:0] len);
    return len - (len >> 1);
  endfunction

endpackage

// File: rtl/isaf_lfsr.sv
module isaf_lfsr #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] SUBST = 16'hACE1,
  parameter logic [W-1:0] TAPS  = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] seed,
  output logic [W-1:0] rnd
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = {1'b0, rnd[W-1:1]};
    if (rnd[0]) nxt = nxt ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rnd <= (seed == '0) ? SUBST : seed;
    else        rnd <= nxt;
  end

  // R9: generator never collapses into the all-zero lock-up state
  assert_lfsr_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rnd != '0);

endmodule

// File: rtl/isaf_seq.sv
module isaf_seq
  import isaf_pkg::*;
#(
  parameter int unsigned LEN_MIN = 10,
  parameter int unsigned LEN_MAX = 30,
  parameter int unsigned WAIT_W  = 4,
  parameter int unsigned LIM_W   = 8,
  parameter int unsigned RND_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [RND_W-1:0] rnd,
  input  logic [LIM_W-1:0] burst_limit,
  output logic             active,
  output logic             arm
);
  localparam int unsigned CNT_W = $clog2(LEN_MAX + 1);

  isaf_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] gap_len;
  logic [LIM_W-1:0] done_n;
  logic [7:0]       len_draw;
  logic             cnt_zero;
  logic             last_burst;
  logic             len_load;

  assign len_draw   = isaf_len(rnd, LEN_MIN, LEN_MAX);
  assign cnt_zero   = (cnt == '0);
  assign last_burst = (burst_limit != '0) && (done_n + 1'b1 == burst_limit);
  assign len_load   = en && cnt_zero &&
                      ((state == ST_WAIT) || (state == ST_GAP && !last_burst));
  assign arm        = en && (state == ST_IDLE);
  assign active     = (state == ST_ACT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      gap_len <= '0;
      done_n  <= '0;
    end else if (!en) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (len_load) begin
      state   <= ST_ACT;
      cnt     <= CNT_W'(isaf_act(len_draw) - 8'd1);
      gap_len <= CNT_W'(isaf_gap(len_draw));
      if (state == ST_GAP) done_n <= done_n + 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          state  <= ST_WAIT;
          cnt    <= CNT_W'(rnd[WAIT_W-1:0]);
          done_n <= '0;
        end
        ST_WAIT: cnt <= cnt - 1'b1;
        ST_ACT: begin
          if (cnt_zero) begin
            state <= ST_GAP;
            cnt   <= gap_len - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt_zero) begin
            state  <= ST_DONE;
            done_n <= done_n + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  // R4: every drawn burst length lies inside the bounded range
  assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    len_load |-> (len_draw >= 8'(LEN_MIN) && len_draw <= 8'(LEN_MAX)));

  // R4: a drawn length always opens an active window
  assert_len_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    len_load |=> active);

  // R6: the block only stops once the configured count is reached
  assert_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |-> (done_n == burst_limit));

  // R7: dropping enable clears the fault after one edge
  assert_en_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !active);

endmodule

// File: rtl/isaf_mask.sv
module isaf_mask #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic              hit,
  input  logic [IDX_W-1:0]  sel,
  input  logic              level,
  output logic [DATA_W-1:0] dout
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign dout[i] = (hit && (sel == IDX_W'(i))) ? level : din[i];
  end
endmodule

// File: rtl/isaf_injector.sv
module isaf_injector #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned IDX_W   = $clog2(DATA_W),
  parameter int unsigned LIM_W   = 8,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned LEN_MIN = 10,
  parameter int unsigned LEN_MAX = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inject_en,
  input  logic [15:0]       seed,
  input  logic [IDX_W-1:0]  bit_sel,
  input  logic              stuck_hi,
  input  logic [LIM_W-1:0]  burst_limit,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] word_out,
  output logic              fault_on,
  output logic [CNT_W-1:0]  inj_cycles
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [15:0]      rnd;
  logic             arm;
  logic [IDX_W-1:0] sel_q;
  logic             lvl_q;

  isaf_lfsr u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .seed (seed),
    .rnd  (rnd)
  );

  isaf_seq #(
    .LEN_MIN(LEN_MIN),
    .LEN_MAX(LEN_MAX),
    .LIM_W  (LIM_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (inject_en),
    .rnd        (rnd),
    .burst_limit(burst_limit),
    .active     (fault_on),
    .arm        (arm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      lvl_q <= 1'b0;
    end else if (arm) begin
      sel_q <= bit_sel;
      lvl_q <= stuck_hi;
    end
  end

  isaf_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
    .din  (word_in),
    .hit  (fault_on),
    .sel  (sel_q),
    .level(lvl_q),
    .dout (word_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                            inj_cycles <= '0;
    else if (fault_on && inj_cycles != CNT_MAX) inj_cycles <= inj_cycles + 1'b1;
  end

  // R1: pass-through outside the active window
  assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_on |-> (word_out == word_in));

  // R2: the captured bit holds the captured level while active
  assert_stuck_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_on |-> (word_out[sel_q] == lvl_q));

  // R2: no more than the one targeted bit differs from the input
  assert_single_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_on |-> ($countones(word_out ^ word_in) <= 1));

  // R3: the location stays put for the whole run
  assert_hold_loc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_on && $past(fault_on)) |-> ($stable(sel_q) && $stable(lvl_q)));

  // R8: one step per active cycle until saturation
  assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_on && inj_cycles != CNT_MAX) |=> (inj_cycles == $past(inj_cycles) + 1'b1));

  // R8: counter holds when no fault was applied
  assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_on |=> $stable(inj_cycles));

endmodule

// File: tb/isaf_injector_bench.sv
module isaf_injector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inject_en = 1'b0;
  logic [15:0] seed = 16'h0;
  logic [2:0]  bit_sel = 3'd0;
  logic        stuck_hi = 1'b0;
  logic [7:0]  burst_limit = 8'd0;
  logic [7:0]  word_in = 8'h00;
  logic [7:0]  word_out;
  logic        fault_on;
  logic [31:0] inj_cycles;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  isaf_injector u_isaf_injector (
    .clk(clk), .rst_n(rst_n), .inject_en(inject_en), .seed(seed),
    .bit_sel(bit_sel), .stuck_hi(stuck_hi), .burst_limit(burst_limit),
    .word_in(word_in), .word_out(word_out), .fault_on(fault_on),
    .inj_cycles(inj_cycles)
  );

  // {seed, target bit, stuck level, burst limit}
  localparam int NV = 6;
  localparam logic [27:0] VEC [NV] = '{
    {16'h1234, 3'd0, 1'b1, 8'd3},
    {16'h8001, 3'd7, 1'b0, 8'd3},
    {16'h5A5A, 3'd4, 1'b1, 8'd1},
    {16'hC3E7, 3'd2, 1'b0, 8'd5},
    {16'h0F0F, 3'd6, 1'b1, 8'd0},
    {16'h7777, 3'd1, 1'b0, 8'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] sd);
    @(negedge clk);
    inject_en = 1'b0;
    seed = sd;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Expected read value, stated from R1/R2.
  function automatic logic [7:0] model_out(input logic [7:0] d, input logic on,
                                           input logic [2:0] b, input logic l);
    logic [7:0] r;
    r = d;
    if (on) r[b] = l;
    return r;
  endfunction

  task automatic run_cfg(input logic [15:0] sd, input logic [2:0] t, input logic p,
                         input logic [7:0] lim, input int ncyc,
                         output int start, output int a0, output int nb,
                         output int tot);
    int run, lastA, bad_data, bad_len, bad_gap;
    logic prev;
    do_reset(sd);
    bit_sel = t; stuck_hi = p; burst_limit = lim;
    #1;
    chk(fault_on == 1'b0, "R8", "reset fault_on", fault_on, 0);
    chk(inj_cycles == 0, "R8", "reset count", inj_cycles, 0);
    start = -1; a0 = -1; nb = 0; tot = 0; run = 0; lastA = 0;
    bad_data = 0; bad_len = 0; bad_gap = 0; prev = 1'b0;
    @(negedge clk);
    inject_en = 1'b1;
    for (int c = 1; c <= ncyc; c++) begin
      @(posedge clk); #1;
      if (word_out != model_out(word_in, fault_on, t, p)) begin
        if (bad_data == 0)
          $display("FAIL R2 data cycle %0d: actual %0h expected %0h", c, word_out,
                   model_out(word_in, fault_on, t, p));
        bad_data++;
      end
      if (fault_on) tot++;
      if (fault_on && !prev) begin
        if (start < 0) start = c;
        if (nb > 0 && !(run == lastA || run == lastA + 1)) bad_gap++;
        run = 1;
      end else if (fault_on == prev) begin
        run++;
      end else begin
        lastA = run;
        if (run < 5 || run > 15) bad_len++;
        if (nb == 0) a0 = run;
        nb++;
        run = 1;
      end
      prev = fault_on;
      @(negedge clk);
      word_in = 8'(c * 37) ^ 8'hA5;
    end
    inject_en = 1'b0;
    @(posedge clk); #1;
    chk(fault_on == 1'b0, "R7", "fault_on after disable", fault_on, 0);
    chk(inj_cycles == 32'(tot), "R8", "count vs active cycles", inj_cycles, tot);
    chk(bad_data == 0, "R1", "pass/stuck mismatches", bad_data, 0);
    chk(bad_len == 0, "R4", "active window out of 5..15", bad_len, 0);
    chk(bad_gap == 0, "R4", "inactive window not A or A+1", bad_gap, 0);
    chk(start >= 2 && start <= 17, "R5", "first active edge", start, 2);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int st, a, nb, tot, st2, a2, nb2, tot2, lim, bad;
    // Table walk: several seeds, both levels, edge and middle bits, limits
    for (int v = 0; v < NV; v++) begin
      lim = int'(VEC[v][7:0]);
      run_cfg(VEC[v][27:12], VEC[v][11:9], VEC[v][8], VEC[v][7:0],
              (lim == 0) ? 400 : lim * 32 + 40, st, a, nb, tot);
      if (lim != 0) chk(nb == lim, "R6", "bursts with limit", nb, lim);
      else          chk(nb >= 12, "R6", "unlimited bursts", nb, 12);
    end

    // R9: zero seed behaves as the substitute constant
    run_cfg(16'h0000, 3'd3, 1'b1, 8'd4, 200, st, a, nb, tot);
    run_cfg(16'hACE1, 3'd3, 1'b1, 8'd4, 200, st2, a2, nb2, tot2);
    chk(st == st2, "R9", "zero-seed start", st, st2);
    chk(a == a2 && tot == tot2, "R9", "zero-seed pattern", tot, tot2);
    // R9: same seed repeats
    run_cfg(16'h2468, 3'd5, 1'b0, 8'd2, 120, st, a, nb, tot);
    run_cfg(16'h2468, 3'd5, 1'b0, 8'd2, 120, st2, a2, nb2, tot2);
    chk(st == st2 && a == a2 && tot == tot2, "R9", "repeat seed", tot, tot2);

    // R3: location and level change after arming are ignored
    do_reset(16'h3141);
    bit_sel = 3'd2; stuck_hi = 1'b1; burst_limit = 8'd0;
    @(negedge clk); inject_en = 1'b1;
    @(negedge clk); bit_sel = 3'd5; stuck_hi = 1'b0;
    bad = 0;
    for (int c = 0; c < 200; c++) begin
      @(posedge clk); #1;
      if (word_out != model_out(word_in, fault_on, 3'd2, 1'b1)) bad++;
      @(negedge clk); word_in = 8'(c * 91) ^ 8'h3C;
    end
    chk(bad == 0, "R3", "captured target held", bad, 0);

    // R7: disable in the middle of an active window
    do_reset(16'h9ABC);
    bit_sel = 3'd0; stuck_hi = 1'b1; burst_limit = 8'd0; word_in = 8'h00;
    @(negedge clk); inject_en = 1'b1;
    for (int c = 0; c < 40 && !fault_on; c++) @(negedge clk);
    @(negedge clk);
    chk(fault_on == 1'b1, "R7", "active before disable", fault_on, 1);
    inject_en = 1'b0;
    @(posedge clk); #1;
    chk(fault_on == 1'b0, "R7", "off one edge after disable", fault_on, 0);
    chk(word_out == word_in, "R1", "pass-through after disable", word_out, word_in);
    tot = int'(inj_cycles);
    repeat (5) @(posedge clk);
    #1;
    chk(inj_cycles == 32'(tot), "R7", "count frozen", inj_cycles, tot);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule